// File: doc/BRIEF.md
# Adaptive inter-frame gap timer

This block sits on the transmit side of an Ethernet MAC and decides when the next frame may begin after the last event on the wire. It watches three one-cycle strobes: end of a transmitted frame, end of a received frame, and a collision that forces a retry. It also watches a level that says whether another transmit frame is already queued. From these it records what kind of gap is now running and holds a transmit-permit output low until that gap has run out.

All gap lengths are counted in byte times. A prescaler divides the single core clock down to one tick per byte time, with a separate divisor for each link speed. The standard floor is 12 byte times, which is 96 bit times at every speed. A programmable base gap applies to every kind of event. A second programmable adaptive gap applies only when one transmit follows another with a frame already waiting. The gap used is the largest of the values that apply; they are never added together. If the link speed changes while a gap is running, the count starts again at the new speed, so the gap can never come out shorter.

Top module: `ifg_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `tx_permit` is 1 and no gap is running.
- R2: Any strobe (`tx_done`, `rx_done` or `tx_collision`) sampled on a clock edge drives `tx_permit` to 0 after that edge. A strobe that arrives while a gap is already running starts the count again from zero at that edge.
- R3: No gap is ever shorter than 12 byte times at any speed, whatever the programmed values are. With both programmed values at 0, a gap lasts exactly 12 byte times.
- R4: `speed_sel` is encoded as 0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1 Gb/s, and 3 behaves as 1 Gb/s. With the default divisors, one byte time is 100, 10 and 1 core cycles respectively (800 ns, 80 ns and 8 ns on an 8 ns core clock). A gap of G byte times keeps `tx_permit` low for exactly G times the divisor cycles after the strobe edge.
- R5: Back-to-back is `tx_done` sampled with `tx_pending` at 1. Its gap is the largest of `aifs_val`, `ipg_val` and 12 byte times, never their sum. At 100 Mb/s, for example, an `aifs_val` of 10 has no effect, while 20 lengthens the gap to 200 core cycles.
- R6: After `tx_done` sampled with `tx_pending` at 0, `aifs_val` is ignored and the gap is the larger of `ipg_val` and 12 byte times.
- R7: After `rx_done`, `aifs_val` is ignored and the gap is the larger of `ipg_val` and 12 byte times.
- R8: After `tx_collision`, `aifs_val` is ignored and the gap is the larger of `ipg_val` and 12 byte times.
- R9: When strobes arrive in the same cycle, `tx_collision` takes priority over `rx_done`, and `rx_done` takes priority over `tx_done`. A back-to-back gap is applied only when `tx_done` arrives alone.
- R10: If `speed_sel` changes while a gap is running, the elapsed count is cleared at the edge where the change is sampled. The full gap then runs again at the new byte time.
- R11: While no gap is running and no strobe arrives, `tx_permit` stays at 1, whatever happens to `speed_sel`, `aifs_val`, `ipg_val` and `tx_pending`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 2 | Link speed: 0 = 10 Mb/s, 1 = 100 Mb/s, 2 or 3 = 1 Gb/s |
| aifs_val | input | GAP_W | Adaptive gap in byte times, used for back-to-back transmits only |
| ipg_val | input | GAP_W | Base transmit gap in byte times |
| tx_pending | input | 1 | Another transmit frame is queued |
| tx_done | input | 1 | One-cycle strobe: a transmit frame has ended |
| rx_done | input | 1 | One-cycle strobe: a receive frame has ended |
| tx_collision | input | 1 | One-cycle strobe: a collision forces a retransmission |
| tx_permit | output | 1 | 1 when the next frame may start |

## Verification
The checker counts byte ticks from each strobe and compares the count with the expected gap when `tx_permit` rises. That comparison assumes `aifs_val` and `ipg_val` stay steady while a gap is running, and that strobes are single-cycle pulses. The stimulus changes the programmed values and the speed only while `tx_permit` is high, or on purpose in the mid-gap speed-change tests. There the checker clears its own count on the same edge as the design. Every gap a test starts is left to run out before the next setting is applied.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

   typedef enum logic [1:0] {
      SPD_10M  = 2'd0,
      SPD_100M = 2'd1,
      SPD_1G   = 2'd2,
      SPD_ALT  = 2'd3
   } ifg_speed_e;

   typedef enum logic [2:0] {
      EV_NONE    = 3'd0,
      EV_TX_B2B  = 3'd1,
      EV_TX_IDLE = 3'd2,
      EV_RX      = 3'd3,
      EV_RETRY   = 3'd4
   } ifg_event_e;

endpackage

// File: rtl/ifg_event_decode.sv
module ifg_event_decode
   import ifg_pkg::*;
(
   input  logic       tx_pending,
   input  logic       tx_done,
   input  logic       rx_done,
   input  logic       tx_collision,
   output ifg_event_e ev_kind,
   output logic       ev_valid
);

   // collision over receive over transmit
   always_comb begin
      if (tx_collision)
         ev_kind = EV_RETRY;
      else if (rx_done)
         ev_kind = EV_RX;
      else if (tx_done)
         ev_kind = tx_pending ? EV_TX_B2B : EV_TX_IDLE;
      else
         ev_kind = EV_NONE;
   end

   assign ev_valid = (ev_kind != EV_NONE);

endmodule

// File: rtl/ifg_gap_select.sv
module ifg_gap_select
   import ifg_pkg::*;
#(
   parameter int GAP_W       = 10,
   parameter int MIN_GAP     = 12,
   parameter bit ADAPTIVE_EN = 1'b1
) (
   input  ifg_event_e       ev_kind,
   input  logic [GAP_W-1:0] aifs_val,
   input  logic [GAP_W-1:0] ipg_val,
   output logic [GAP_W-1:0] target
);

   localparam logic [GAP_W-1:0] FLOOR = GAP_W'(MIN_GAP);

   logic [GAP_W-1:0] base_gap;

   assign base_gap = (ipg_val > FLOOR) ? ipg_val : FLOOR;

   generate
      if (ADAPTIVE_EN) begin : g_adaptive
         always_comb begin
            if (ev_kind == EV_TX_B2B && aifs_val > base_gap)
               target = aifs_val;
            else
               target = base_gap;
         end
      end else begin : g_fixed
         logic unused_aifs;
         assign unused_aifs = ^{aifs_val, ev_kind};
         assign target      = base_gap;
      end
   endgenerate

endmodule

// File: rtl/ifg_tick_gen.sv
module ifg_tick_gen
   import ifg_pkg::*;
#(
   parameter int DIV_10M  = 100,
   parameter int DIV_100M = 10,
   parameter int DIV_1G   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] speed_sel,
   input  logic       restart,
   output logic       tick
);

   localparam int DIV_MAX = (DIV_10M > DIV_100M) ?
                            ((DIV_10M > DIV_1G) ? DIV_10M : DIV_1G) :
                            ((DIV_100M > DIV_1G) ? DIV_100M : DIV_1G);
   localparam int PRE_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

   generate
      if (DIV_MAX == 1) begin : g_direct
         logic unused_in;
         assign unused_in = ^{clk, rst_n, speed_sel, restart};
         assign tick      = 1'b1;
      end else begin : g_prescale
         localparam logic [PRE_W-1:0] LAST_10M  = PRE_W'(DIV_10M - 1);
         localparam logic [PRE_W-1:0] LAST_100M = PRE_W'(DIV_100M - 1);
         localparam logic [PRE_W-1:0] LAST_1G   = PRE_W'(DIV_1G - 1);

         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] last_val;

         always_comb begin
            case (speed_sel)
               SPD_10M:  last_val = LAST_10M;
               SPD_100M: last_val = LAST_100M;
               default:  last_val = LAST_1G;
            endcase
         end

         assign tick = (pre_q >= last_val);

         always_ff @(posedge clk) begin
            if (!rst_n)
               pre_q <= '0;
            else if (restart || tick)
               pre_q <= '0;
            else
               pre_q <= pre_q + PRE_W'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter #(
   parameter int GAP_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       speed_sel,
   input  logic             ev_valid,
   input  logic [GAP_W-1:0] target,
   input  logic             tick,
   output logic             restart,
   output logic             busy
);

   logic [GAP_W-1:0] elapsed_q;
   logic [GAP_W-1:0] target_q;
   logic [1:0]       speed_q;
   logic             spd_chg;
   logic [GAP_W-1:0] elapsed_nxt;

   assign spd_chg     = busy && (speed_sel != speed_q);
   assign restart     = ev_valid || spd_chg;
   assign elapsed_nxt = elapsed_q + GAP_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         speed_q <= '0;
      else
         speed_q <= speed_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         elapsed_q <= '0;
         target_q  <= '0;
      end else if (ev_valid) begin
         busy      <= 1'b1;
         elapsed_q <= '0;
         target_q  <= target;
      end else if (spd_chg) begin
         elapsed_q <= '0;
      end else if (busy && tick) begin
         if (elapsed_nxt >= target_q) begin
            busy      <= 1'b0;
            elapsed_q <= '0;
         end else begin
            elapsed_q <= elapsed_nxt;
         end
      end
   end

endmodule

// File: rtl/ifg_gate.sv
module ifg_gate
   import ifg_pkg::*;
#(
   parameter int GAP_W       = 10,
   parameter int MIN_GAP     = 12,
   parameter int DIV_10M     = 100,
   parameter int DIV_100M    = 10,
   parameter int DIV_1G      = 1,
   parameter bit ADAPTIVE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       speed_sel,
   input  logic [GAP_W-1:0] aifs_val,
   input  logic [GAP_W-1:0] ipg_val,
   input  logic             tx_pending,
   input  logic             tx_done,
   input  logic             rx_done,
   input  logic             tx_collision,
   output logic             tx_permit
);

   initial begin
      AST_CFG_GAP_FITS: assert (MIN_GAP > 0 && MIN_GAP < (1 << GAP_W))
         else $error("MIN_GAP does not fit GAP_W");
      AST_CFG_DIVISORS: assert (DIV_10M > 0 && DIV_100M > 0 && DIV_1G > 0)
         else $error("divisors must be positive");
   end

   ifg_event_e       ev_kind;
   logic             ev_valid;
   logic [GAP_W-1:0] target;
   logic             byte_tick;
   logic             restart;
   logic             busy;

   ifg_event_decode u_decode (
      .tx_pending   (tx_pending),
      .tx_done      (tx_done),
      .rx_done      (rx_done),
      .tx_collision (tx_collision),
      .ev_kind      (ev_kind),
      .ev_valid     (ev_valid)
   );

   ifg_gap_select #(
      .GAP_W       (GAP_W),
      .MIN_GAP     (MIN_GAP),
      .ADAPTIVE_EN (ADAPTIVE_EN)
   ) u_select (
      .ev_kind  (ev_kind),
      .aifs_val (aifs_val),
      .ipg_val  (ipg_val),
      .target   (target)
   );

   ifg_tick_gen #(
      .DIV_10M  (DIV_10M),
      .DIV_100M (DIV_100M),
      .DIV_1G   (DIV_1G)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .speed_sel (speed_sel),
      .restart   (restart),
      .tick      (byte_tick)
   );

   ifg_gap_counter #(
      .GAP_W (GAP_W)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .speed_sel (speed_sel),
      .ev_valid  (ev_valid),
      .target    (target),
      .tick      (byte_tick),
      .restart   (restart),
      .busy      (busy)
   );

   assign tx_permit = !busy;

endmodule

// File: rtl/ifg_gate_chk.sv
module ifg_gate_chk #(
   parameter int GAP_W   = 10,
   parameter int MIN_GAP = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       speed_sel,
   input logic [GAP_W-1:0] aifs_val,
   input logic [GAP_W-1:0] ipg_val,
   input logic             tx_pending,
   input logic             tx_done,
   input logic             rx_done,
   input logic             tx_collision,
   input logic             tx_permit,
   input logic             tick
);

   localparam logic [GAP_W:0] FLOOR = (GAP_W+1)'(MIN_GAP);

   logic           any_ev;
   logic           is_b2b;
   logic           last_b2b;
   logic [1:0]     spd_q;
   logic [GAP_W:0] ticks_seen;
   logic [GAP_W:0] exp_plain;
   logic [GAP_W:0] exp_b2b;

   assign any_ev    = tx_done || rx_done || tx_collision;
   assign is_b2b    = tx_done && tx_pending && !rx_done && !tx_collision;
   assign exp_plain = ({1'b0, ipg_val} > FLOOR) ? {1'b0, ipg_val} : FLOOR;
   assign exp_b2b   = ({1'b0, aifs_val} > exp_plain) ? {1'b0, aifs_val} : exp_plain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ticks_seen <= '0;
         last_b2b   <= 1'b0;
         spd_q      <= '0;
      end else begin
         spd_q <= speed_sel;
         if (any_ev) begin
            ticks_seen <= '0;
            last_b2b   <= is_b2b;
         end else if (!tx_permit && speed_sel != spd_q) begin
            ticks_seen <= '0;
         end else if (!tx_permit && tick) begin
            ticks_seen <= ticks_seen + (GAP_W+1)'(1);
         end
      end
   end

   AST_STROBE_CLOSES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      any_ev |=> !tx_permit); // R2

   AST_GATE_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_permit && !any_ev) |=> tx_permit); // R11

   AST_GAP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_permit) |-> (ticks_seen >= FLOOR)); // R3

   AST_B2B_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_permit) && last_b2b) |-> (ticks_seen == exp_b2b)); // R5

   AST_PLAIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_permit) && !last_b2b) |-> (ticks_seen == exp_plain)); // R6

endmodule

bind ifg_gate ifg_gate_chk #(
   .GAP_W   (GAP_W),
   .MIN_GAP (MIN_GAP)
) u_ifg_gate_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .speed_sel    (speed_sel),
   .aifs_val     (aifs_val),
   .ipg_val      (ipg_val),
   .tx_pending   (tx_pending),
   .tx_done      (tx_done),
   .rx_done      (rx_done),
   .tx_collision (tx_collision),
   .tx_permit    (tx_permit),
   .tick         (byte_tick)
);

// File: tb/test_ifg_gate.sv
module test_ifg_gate;

   localparam int CLK_PERIOD = 8;
   localparam int GAP_W      = 10;
   localparam int WATCHDOG   = 100000;

   // kind: 0 tx with pending, 1 tx alone, 2 rx, 3 collision,
   //       4 tx+pending+rx together, 5 collision+tx+pending together
   typedef struct packed {
      logic [1:0]       spd;
      logic [GAP_W-1:0] aifs;
      logic [GAP_W-1:0] ipg;
      logic [2:0]       kind;
      int               req;
      int               exp;
   } vec_t;

   localparam int NVEC = 15;
   localparam vec_t TBL [NVEC] = '{
      '{2'd2, 10'd0,  10'd0,  3'd0, 3, 12},   // R3 floor at 1G
      '{2'd1, 10'd10, 10'd0,  3'd0, 5, 120},  // R5 aifs 10 no effect
      '{2'd1, 10'd20, 10'd0,  3'd0, 5, 200},  // R5 aifs 20 lengthens
      '{2'd1, 10'd20, 10'd15, 3'd0, 5, 200},  // R5 max not sum
      '{2'd1, 10'd20, 10'd25, 3'd0, 5, 250},  // R5 ipg larger
      '{2'd1, 10'd20, 10'd0,  3'd1, 6, 120},  // R6 not back-to-back
      '{2'd1, 10'd20, 10'd0,  3'd2, 7, 120},  // R7 after receive
      '{2'd1, 10'd20, 10'd0,  3'd3, 8, 120},  // R8 retry
      '{2'd2, 10'd30, 10'd14, 3'd2, 7, 14},   // R7 ipg above floor
      '{2'd0, 10'd0,  10'd0,  3'd0, 4, 1200}, // R4 10M byte time
      '{2'd0, 10'd13, 10'd0,  3'd0, 5, 1300}, // R5 at 10M
      '{2'd2, 10'd40, 10'd0,  3'd0, 5, 40},   // R5 at 1G
      '{2'd2, 10'd40, 10'd0,  3'd4, 9, 12},   // R9 rx over tx
      '{2'd2, 10'd40, 10'd0,  3'd5, 9, 12},   // R9 collision over tx
      '{2'd3, 10'd20, 10'd0,  3'd0, 4, 20}    // R4 code 3 as 1G
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       speed_sel = 2'd2;
   logic [GAP_W-1:0] aifs_val = '0;
   logic [GAP_W-1:0] ipg_val = '0;
   logic             tx_pending = 1'b0;
   logic             tx_done = 1'b0;
   logic             rx_done = 1'b0;
   logic             tx_collision = 1'b0;
   logic             tx_permit;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ifg_gate i_ifg_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .speed_sel    (speed_sel),
      .aifs_val     (aifs_val),
      .ipg_val      (ipg_val),
      .tx_pending   (tx_pending),
      .tx_done      (tx_done),
      .rx_done      (rx_done),
      .tx_collision (tx_collision),
      .tx_permit    (tx_permit)
   );

   task automatic check(input string tag, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic fire(input logic [2:0] kind);
      tx_done      = (kind == 3'd0 || kind == 3'd1 || kind == 3'd4 || kind == 3'd5);
      tx_pending   = (kind == 3'd0 || kind == 3'd4 || kind == 3'd5);
      rx_done      = (kind == 3'd2 || kind == 3'd4);
      tx_collision = (kind == 3'd3 || kind == 3'd5);
   endtask

   task automatic quiet();
      tx_done      = 1'b0;
      rx_done      = 1'b0;
      tx_collision = 1'b0;
      tx_pending   = 1'b0;
   endtask

   // act 1: rx strobe, act 2: speed change; applied when n == act_at
   task automatic measure(input logic [2:0] kind, input int act_at, input int act,
                          input logic [1:0] new_spd, output int n);
      fire(kind);
      @(negedge clk);
      n = 0;
      while (!tx_permit && n < 5000) begin
         quiet();
         if (n == act_at && act == 1) rx_done = 1'b1;
         if (n == act_at && act == 2) speed_sel = new_spd;
         n++;
         @(negedge clk);
      end
      quiet();
      @(negedge clk);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check("R1 permit during reset", int'(tx_permit), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 permit after reset", int'(tx_permit), 1);

      for (int i = 0; i < NVEC; i++) begin
         speed_sel = TBL[i].spd;
         aifs_val  = TBL[i].aifs;
         ipg_val   = TBL[i].ipg;
         @(negedge clk);
         measure(TBL[i].kind, -1, 0, 2'd0, n);
         check($sformatf("R%0d vector %0d gap cycles", TBL[i].req, i), n, TBL[i].exp);
      end

      // R11: idle, inputs move, no strobe
      begin
         int low = 0;
         for (int k = 0; k < 40; k++) begin
            speed_sel  = 2'(k % 3);
            aifs_val   = GAP_W'(k * 7);
            ipg_val    = GAP_W'(k * 3);
            tx_pending = k[0];
            @(negedge clk);
            if (!tx_permit) low++;
         end
         tx_pending = 1'b0;
         check("R11 permit stays open while idle", low, 0);
      end

      // R2: second strobe mid-gap restarts count
      speed_sel = 2'd2; aifs_val = '0; ipg_val = '0;
      @(negedge clk);
      measure(3'd0, 4, 1, 2'd0, n);
      check("R2 restart on strobe mid-gap", n, 4 + 1 + 12);

      // R2: permit drops right after the strobe edge
      fire(3'd3);
      @(negedge clk);
      quiet();
      check("R2 permit low after strobe", int'(tx_permit), 0);
      repeat (20) @(negedge clk);
      check("R2 permit back after gap", int'(tx_permit), 1);

      // R10: 100M to 1G mid-gap
      speed_sel = 2'd1;
      @(negedge clk);
      measure(3'd0, 29, 2, 2'd2, n);
      check("R10 speed change 100M to 1G", n, 30 + 12);

      // R10: 1G to 10M mid-gap
      speed_sel = 2'd2;
      @(negedge clk);
      measure(3'd2, 4, 2, 2'd0, n);
      check("R10 speed change 1G to 10M", n, 5 + 1200);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule